// File: doc/BRIEF.md
# Clean-Line Read Cache Controller with Write-Cache Steering

This block manages the tags and line state of a small read cache that sits beside a separate write-combining cache. It never holds modified data. Stores are not written into it. A store is only reported to it, so that it can mark a resident line as overtaken by newer bytes in the write cache. Each line carries a valid bit, a tag, one data word and a "written" flag. Loads that find a valid line with the flag clear are answered locally and do not touch the write cache. Every other load first asks the write cache. If that cache holds every requested byte, it supplies the answer. If it does not, it writes its dirty bytes out, and only then is a miss sent to the next level.

Lines are invalidated by two sources: evictions from the local write cache and broadcasts from elsewhere in the system. Neither ever produces a data reply, because a line can only be clean. A synchronizing (acquire) load needs no special handling and is issued on the ordinary load port. The tags are direct-mapped, and only one miss may be outstanding, so new loads are held off until the pending one is answered. If an invalidation of the missing address is seen while the miss is pending, the fill data is still returned to the requester but is not kept in the cache. This includes an invalidation in the same cycle as the fill. If a store to that address is reported while the miss is pending, the line is installed with its written flag already set.

Top module: `rocache_steer`

## Requirements
- R1: After reset, `ldReady` is 1, `rspValid`, `wcProbeValid` and `missValid` are 0, and no line is valid, so the first load to any address probes the write cache.
- R2: A load accepted (`ldValid` and `ldReady` high at a clock edge) whose address matches a valid line with the written flag clear produces `rspValid` in the next cycle, with `rspSrc` = 0 (local) and the line's data, and `wcProbeValid` stays 0.
- R3: A store notification (`stValid`, `stAddr`) whose address matches a valid line sets that line's written flag, so later loads to it probe the write cache. A store notification to an address that is not resident changes nothing. A store notification in the same cycle as a load to the same address already steers that load to the write cache.
- R4: A load that misses, or that hits a line with the written flag set, raises `wcProbeValid` for one cycle, in the cycle after acceptance, with `wcProbeAddr` and `wcProbeMask` equal to the load's address and byte mask. If the write-cache reply has `wcRspFull` = 1, the response follows one cycle after that reply, with `rspSrc` = 1 and `rspData` = `wcRspData`. `rspSrc` never takes the value 3.
- R5: If the write-cache reply has `wcRspFull` = 0, which signals that its dirty bytes for the address have been written out, `missValid` pulses for exactly one cycle, in the cycle after that reply, with `missAddr` equal to the load address. It never pulses without such a reply. The response follows one cycle after `fillValid`, with `rspSrc` = 2 and `rspData` = `fillData`, and the line is installed valid with its written flag clear.
- R6: A write-cache eviction (`evictValid`, `evictAddr`) or an external broadcast (`bcastValid`, `bcastAddr`) that matches a resident line clears only its valid bit and never produces a response. A load in the same cycle as such an invalidation of its own address is not answered locally.
- R7: If an invalidation of the missing address arrives while the miss is pending, including in the same cycle as `fillValid`, the fill data is returned but not retained, and the next load to that address misses again.
- R8: If a store notification for the missing address arrives while the miss is pending (including the fill cycle), the fill installs the line with its written flag set, and the next load to it probes the write cache.
- R9: `ldReady` is 0 from the cycle after acceptance of a non-local load until its response cycle. At most one of `rspValid`, `wcProbeValid` and `missValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load request present |
| ldReady | output | 1 | Load accepted at this edge if `ldValid` is high |
| ldAddr | input | ADDR_W (12) | Load word address; low IDX_W bits are the set index, the rest is the tag |
| ldMask | input | DATA_W/8 (4) | Bytes the load needs |
| rspValid | output | 1 | Load response present for one cycle |
| rspSrc | output | 2 | Response origin: 0 local line, 1 write cache, 2 next level |
| rspData | output | DATA_W (32) | Response data word |
| stValid | input | 1 | Store notification present |
| stAddr | input | ADDR_W | Address of the notified store |
| evictValid | input | 1 | Write-cache eviction present |
| evictAddr | input | ADDR_W | Evicted address |
| bcastValid | input | 1 | External invalidate broadcast present |
| bcastAddr | input | ADDR_W | Broadcast address |
| wcProbeValid | output | 1 | Probe to the write cache, one cycle |
| wcProbeAddr | output | ADDR_W | Probed address |
| wcProbeMask | output | DATA_W/8 | Probed byte mask |
| wcRspValid | input | 1 | Write-cache probe reply |
| wcRspFull | input | 1 | 1: all probed bytes are dirty there; 0: its dirty bytes were flushed |
| wcRspData | input | DATA_W | Write-cache data on a full reply |
| missValid | output | 1 | Miss request to the next level, one-cycle pulse |
| missAddr | output | ADDR_W | Miss address |
| fillValid | input | 1 | Fill response from the next level |
| fillData | input | DATA_W | Fill data word |

## Verification
The functions that can collide are filling a line on a pending miss and invalidating that same line (or marking it written through a store notification). A load being looked up while an invalidation or store for its address arrives is a second collision of the same kind. The bench provokes these directly, by driving the fill together with a broadcast for the missing address, by reporting a store between the miss and the fill, and by presenting a load in the same cycle as a broadcast or store to its address. Each case is judged at the ports only: the data of the returned word and its origin code, followed by whether the next load to that address is answered locally, probes the write cache, or misses again.

// File: rtl/rocache_pkg.sv
package rocache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_MISS  = 2'd2
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;         // latch the accepted load request
    logic rspCache;        // answer from the local line
    logic rspWc;           // answer from the write cache
    logic rspFill;         // answer from the next level
    logic install;         // keep the fill in the array
    logic installWritten;  // installed line starts marked written
  } dpStrobe_t;

  localparam logic [1:0] SRC_LOCAL  = 2'd0;
  localparam logic [1:0] SRC_WCACHE = 2'd1;
  localparam logic [1:0] SRC_NEXT   = 2'd2;

endpackage

// File: rtl/rocache_dp.sv
module rocache_dp
  import rocache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [DATA_W/8-1:0] ldMask,
  input  logic                stValid,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic                evictValid,
  input  logic [ADDR_W-1:0]   evictAddr,
  input  logic                bcastValid,
  input  logic [ADDR_W-1:0]   bcastAddr,
  input  logic [DATA_W-1:0]   wcRspData,
  input  logic [DATA_W-1:0]   fillData,
  output logic                cleanHit,
  output logic                pendInv,
  output logic                pendSt,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [DATA_W/8-1:0] reqMask,
  output logic                rspValid,
  output logic [1:0]          rspSrc,
  output logic [DATA_W-1:0]   rspData
);

  localparam int SETS   = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int MASK_W = DATA_W / 8;

  logic [SETS-1:0]   validVec;
  logic [SETS-1:0]   writtenVec;
  logic [TAG_W-1:0]  tagArr  [SETS];
  logic [DATA_W-1:0] dataArr [SETS];

  logic [ADDR_W-1:0] reqAddrQ;
  logic [MASK_W-1:0] reqMaskQ;

  logic [IDX_W-1:0]  lkIdx;
  logic [TAG_W-1:0]  lkTag;
  logic              invOnLoad;
  logic              stOnLoad;

  // Lookup for the load presented this cycle
  always_comb begin
    lkIdx     = ldAddr[IDX_W-1:0];
    lkTag     = ldAddr[ADDR_W-1:IDX_W];
    invOnLoad = (evictValid && (evictAddr == ldAddr)) ||
                (bcastValid && (bcastAddr == ldAddr));
    stOnLoad  = stValid && (stAddr == ldAddr);
    cleanHit  = validVec[lkIdx] && (tagArr[lkIdx] == lkTag) &&
                !writtenVec[lkIdx] && !invOnLoad && !stOnLoad;
  end

  // Events that concern the request being served
  always_comb begin
    pendInv = (evictValid && (evictAddr == reqAddrQ)) ||
              (bcastValid && (bcastAddr == reqAddrQ));
    pendSt  = stValid && (stAddr == reqAddrQ);
  end

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ <= '0;
      reqMaskQ <= '0;
    end else if (strobe.capture) begin
      reqAddrQ <= ldAddr;
      reqMaskQ <= ldMask;
    end
  end

  assign reqAddr = reqAddrQ;
  assign reqMask = reqMaskQ;

  // Per-set line state
  for (genvar gi = 0; gi < SETS; gi++) begin : g_set
    logic              lineValid;
    logic              lineWritten;
    logic [TAG_W-1:0]  lineTag;
    logic [DATA_W-1:0] lineData;
    logic              selInstall;
    logic              killLine;
    logic              markLine;

    always_comb begin
      selInstall = strobe.install && (reqAddrQ[IDX_W-1:0] == IDX_W'(gi));
      killLine   = lineValid &&
                   ((evictValid && (evictAddr[IDX_W-1:0] == IDX_W'(gi)) &&
                     (evictAddr[ADDR_W-1:IDX_W] == lineTag)) ||
                    (bcastValid && (bcastAddr[IDX_W-1:0] == IDX_W'(gi)) &&
                     (bcastAddr[ADDR_W-1:IDX_W] == lineTag)));
      markLine   = lineValid && stValid &&
                   (stAddr[IDX_W-1:0] == IDX_W'(gi)) &&
                   (stAddr[ADDR_W-1:IDX_W] == lineTag);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid   <= 1'b0;
        lineWritten <= 1'b0;
        lineTag     <= '0;
        lineData    <= '0;
      end else if (selInstall) begin
        lineValid   <= 1'b1;
        lineWritten <= strobe.installWritten;
        lineTag     <= reqAddrQ[ADDR_W-1:IDX_W];
        lineData    <= fillData;
      end else if (killLine) begin
        lineValid   <= 1'b0;
        lineWritten <= 1'b0;
      end else if (markLine) begin
        lineWritten <= 1'b1;
      end
    end

    assign validVec[gi]   = lineValid;
    assign writtenVec[gi] = lineWritten;
    assign tagArr[gi]     = lineTag;
    assign dataArr[gi]    = lineData;
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspSrc   <= SRC_LOCAL;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.rspCache || strobe.rspWc || strobe.rspFill;
      if (strobe.rspCache) begin
        rspSrc  <= SRC_LOCAL;
        rspData <= dataArr[lkIdx];
      end else if (strobe.rspWc) begin
        rspSrc  <= SRC_WCACHE;
        rspData <= wcRspData;
      end else if (strobe.rspFill) begin
        rspSrc  <= SRC_NEXT;
        rspData <= fillData;
      end
    end
  end

endmodule

// File: rtl/rocache_ctrl.sv
module rocache_ctrl
  import rocache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ldValid,
  input  logic      cleanHit,
  input  logic      pendInv,
  input  logic      pendSt,
  input  logic      wcRspValid,
  input  logic      wcRspFull,
  input  logic      fillValid,
  output logic      ldReady,
  output dpStrobe_t strobe,
  output logic      wcProbeValid,
  output logic      missValid
);

  ctrlState_e stateQ, stateD;
  logic       probeQ;
  logic       missQ;
  logic       noKeepQ;   // invalidation seen during the miss window
  logic       markedQ;   // store to the pending address seen

  always_comb begin
    stateD  = stateQ;
    strobe  = '0;
    ldReady = (stateQ == ST_IDLE);
    unique case (stateQ)
      ST_IDLE: begin
        if (ldValid) begin
          strobe.capture = 1'b1;
          if (cleanHit) strobe.rspCache = 1'b1;
          else          stateD = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (wcRspValid) begin
          if (wcRspFull) begin
            strobe.rspWc = 1'b1;
            stateD       = ST_IDLE;
          end else begin
            stateD = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        if (fillValid) begin
          strobe.rspFill        = 1'b1;
          strobe.install        = !(noKeepQ || pendInv);
          strobe.installWritten = markedQ || pendSt;
          stateD                = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      probeQ  <= 1'b0;
      missQ   <= 1'b0;
      noKeepQ <= 1'b0;
      markedQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      probeQ <= (stateQ == ST_IDLE) && ldValid && !cleanHit;
      missQ  <= (stateQ == ST_PROBE) && wcRspValid && !wcRspFull;
      if (stateQ != ST_MISS) noKeepQ <= 1'b0;
      else if (pendInv)      noKeepQ <= 1'b1;
      if (stateQ == ST_IDLE) markedQ <= 1'b0;
      else if (pendSt)       markedQ <= 1'b1;
    end
  end

  assign wcProbeValid = probeQ;
  assign missValid    = missQ;

endmodule

// File: rtl/rocache_steer.sv
module rocache_steer
  import rocache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ldValid,
  output logic                ldReady,
  input  logic [ADDR_W-1:0]   ldAddr,
  input  logic [DATA_W/8-1:0] ldMask,
  output logic                rspValid,
  output logic [1:0]          rspSrc,
  output logic [DATA_W-1:0]   rspData,
  input  logic                stValid,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic                evictValid,
  input  logic [ADDR_W-1:0]   evictAddr,
  input  logic                bcastValid,
  input  logic [ADDR_W-1:0]   bcastAddr,
  output logic                wcProbeValid,
  output logic [ADDR_W-1:0]   wcProbeAddr,
  output logic [DATA_W/8-1:0] wcProbeMask,
  input  logic                wcRspValid,
  input  logic                wcRspFull,
  input  logic [DATA_W-1:0]   wcRspData,
  output logic                missValid,
  output logic [ADDR_W-1:0]   missAddr,
  input  logic                fillValid,
  input  logic [DATA_W-1:0]   fillData
);

  dpStrobe_t           strobe;
  logic                cleanHit;
  logic                pendInv;
  logic                pendSt;
  logic [ADDR_W-1:0]   reqAddr;
  logic [DATA_W/8-1:0] reqMask;

  rocache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ldValid      (ldValid),
    .cleanHit     (cleanHit),
    .pendInv      (pendInv),
    .pendSt       (pendSt),
    .wcRspValid   (wcRspValid),
    .wcRspFull    (wcRspFull),
    .fillValid    (fillValid),
    .ldReady      (ldReady),
    .strobe       (strobe),
    .wcProbeValid (wcProbeValid),
    .missValid    (missValid)
  );

  rocache_dp #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ldAddr     (ldAddr),
    .ldMask     (ldMask),
    .stValid    (stValid),
    .stAddr     (stAddr),
    .evictValid (evictValid),
    .evictAddr  (evictAddr),
    .bcastValid (bcastValid),
    .bcastAddr  (bcastAddr),
    .wcRspData  (wcRspData),
    .fillData   (fillData),
    .cleanHit   (cleanHit),
    .pendInv    (pendInv),
    .pendSt     (pendSt),
    .reqAddr    (reqAddr),
    .reqMask    (reqMask),
    .rspValid   (rspValid),
    .rspSrc     (rspSrc),
    .rspData    (rspData)
  );

  assign wcProbeAddr = reqAddr;
  assign wcProbeMask = reqMask;
  assign missAddr    = reqAddr;

endmodule

// File: rtl/rocache_steer_chk.sv
module rocache_steer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ldValid,
  input logic       ldReady,
  input logic       rspValid,
  input logic [1:0] rspSrc,
  input logic       wcProbeValid,
  input logic       wcRspValid,
  input logic       wcRspFull,
  input logic       missValid
);

  // R2 / R4: an accepted load is answered locally or probes next cycle
  p_accept_reply_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldReady) |=> (rspValid || wcProbeValid));

  // R9: response, probe and miss are mutually exclusive
  p_single_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspValid, wcProbeValid, missValid}));

  // R9: no new load is taken while a probe is out
  p_probe_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    wcProbeValid |-> !ldReady);

  // R9: no new load is taken while a miss is issued
  p_miss_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> !ldReady);

  // R5: a miss follows only a non-full write-cache reply
  p_miss_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> $past(wcRspValid && !wcRspFull));

  // R5: the miss request is a single-cycle pulse
  p_miss_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> !missValid);

  // R4: response origin code is never the unused value
  p_src_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspSrc != 2'd3));

endmodule

bind rocache_steer rocache_steer_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ldValid      (ldValid),
  .ldReady      (ldReady),
  .rspValid     (rspValid),
  .rspSrc       (rspSrc),
  .wcProbeValid (wcProbeValid),
  .wcRspValid   (wcRspValid),
  .wcRspFull    (wcRspFull),
  .missValid    (missValid)
);

// File: tb/rocache_steer_tb.sv
module rocache_steer_tb;

  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ldValid = 1'b0;
  logic              ldReady;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic [3:0]        ldMask = '0;
  logic              rspValid;
  logic [1:0]        rspSrc;
  logic [31:0]       rspData;
  logic              stValid = 1'b0;
  logic [ADDR_W-1:0] stAddr = '0;
  logic              evictValid = 1'b0;
  logic [ADDR_W-1:0] evictAddr = '0;
  logic              bcastValid = 1'b0;
  logic [ADDR_W-1:0] bcastAddr = '0;
  logic              wcProbeValid;
  logic [ADDR_W-1:0] wcProbeAddr;
  logic [3:0]        wcProbeMask;
  logic              wcRspValid = 1'b0;
  logic              wcRspFull = 1'b0;
  logic [31:0]       wcRspData = '0;
  logic              missValid;
  logic [ADDR_W-1:0] missAddr;
  logic              fillValid = 1'b0;
  logic [31:0]       fillData = '0;

  always #5 clk = ~clk;

  rocache_steer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (.*);

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // Reference state: 8 pool addresses, pairs p and p+4 share a set
  logic [31:0] mem    [8];
  logic [3:0]  wcMask [8];
  logic [31:0] wcData [8];
  bit          mValid   [8];
  bit          mWritten [8];
  int          mOwner   [8];  // pool index held by the set
  logic [31:0] mData    [8];

  function automatic logic [ADDR_W-1:0] poolAddr(int p);
    logic [8:0] tg;
    tg = (p >= 4) ? 9'h05A : 9'h003;
    return {tg, 3'(p % 4)};
  endfunction

  function automatic logic [31:0] mergeB(logic [31:0] base, logic [31:0] upd, logic [3:0] m);
    logic [31:0] r;
    r = base;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = upd[b*8 +: 8];
    return r;
  endfunction

  function automatic bit resident(int p);
    return mValid[p % 4] && (mOwner[p % 4] == p);
  endfunction

  function automatic void modelInval(int p);
    if (resident(p)) begin
      mValid[p % 4]   = 1'b0;
      mWritten[p % 4] = 1'b0;
    end
  endfunction

  function automatic void modelStore(int p, logic [3:0] m, logic [31:0] d);
    wcData[p] = mergeB(wcData[p], d, m);
    wcMask[p] = wcMask[p] | m;
    if (resident(p)) mWritten[p % 4] = 1'b1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One load with optional same-cycle events at acceptance, a store during
  // the miss, and an invalidation in the fill cycle.
  task automatic doLoad(int p, logic [3:0] m, bit invAcc, bit stAcc, bit stMiss, bit invFill);
    logic [ADDR_W-1:0] a;
    bit expLocal, full, marked;
    logic [31:0] sd;
    a = poolAddr(p);
    @(negedge clk);
    ldValid = 1'b1; ldAddr = a; ldMask = m;
    if (invAcc) begin bcastValid = 1'b1; bcastAddr = a; modelInval(p); end
    if (stAcc) begin
      sd = $urandom; stValid = 1'b1; stAddr = a; modelStore(p, 4'h1, sd);
    end
    expLocal = resident(p) && !mWritten[p % 4];
    chk(ldReady == 1'b1, "R9", "ready when idle", 32'(ldReady), 1);
    @(negedge clk);
    ldValid = 1'b0; bcastValid = 1'b0; stValid = 1'b0;
    if (expLocal) begin
      chk(rspValid && rspSrc == 2'd0, "R2", "local hit src", 32'(rspSrc), 0);
      chk(rspData == mData[p % 4], "R2", "local hit data", rspData, mData[p % 4]);
      chk(!wcProbeValid, "R2", "no probe on clean hit", 32'(wcProbeValid), 0);
      return;
    end
    chk(wcProbeValid && wcProbeAddr == a && wcProbeMask == m, "R4", "probe addr",
        32'(wcProbeAddr), 32'(a));
    chk(!rspValid, "R4", "no local response", 32'(rspValid), 0);
    chk(!ldReady, "R9", "stall during probe", 32'(ldReady), 0);
    full = ((wcMask[p] & m) == m);
    wcRspValid = 1'b1; wcRspFull = full; wcRspData = wcData[p];
    if (!full) begin
      mem[p]    = mergeB(mem[p], wcData[p], wcMask[p]);
      wcMask[p] = 4'h0;
    end
    @(negedge clk);
    wcRspValid = 1'b0; wcRspFull = 1'b0;
    if (full) begin
      chk(rspValid && rspSrc == 2'd1, "R4", "write-cache src", 32'(rspSrc), 1);
      chk(rspData == wcData[p], "R4", "write-cache data", rspData, wcData[p]);
      return;
    end
    chk(missValid && missAddr == a, "R5", "miss addr", 32'(missAddr), 32'(a));
    chk(!ldReady, "R9", "stall during miss", 32'(ldReady), 0);
    marked = 1'b0;
    if (stMiss) begin
      sd = $urandom; stValid = 1'b1; stAddr = a; modelStore(p, 4'h3, sd); marked = 1'b1;
      @(negedge clk);
      stValid = 1'b0;
      chk(!missValid && !rspValid, "R5", "miss pulse single", 32'(missValid), 0);
    end
    fillValid = 1'b1; fillData = mem[p];
    if (invFill) begin bcastValid = 1'b1; bcastAddr = a; modelInval(p); end
    @(negedge clk);
    fillValid = 1'b0; bcastValid = 1'b0;
    chk(rspValid && rspSrc == 2'd2, "R5", "next-level src", 32'(rspSrc), 2);
    chk(rspData == mem[p], "R5", "fill data", rspData, mem[p]);
    chk(ldReady, "R9", "ready after fill", 32'(ldReady), 1);
    if (!invFill) begin
      mValid[p % 4] = 1'b1; mOwner[p % 4] = p; mData[p % 4] = mem[p];
      mWritten[p % 4] = marked;
    end
  endtask

  task automatic doStore(int p, logic [3:0] m, logic [31:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = poolAddr(p); modelStore(p, m, d);
    @(negedge clk);
    stValid = 1'b0;
    chk(!rspValid && !wcProbeValid && !missValid, "R3", "store makes no output",
        32'({rspValid, wcProbeValid, missValid}), 0);
  endtask

  task automatic doEvict(int p);
    @(negedge clk);
    evictValid = 1'b1; evictAddr = poolAddr(p);
    mem[p] = mergeB(mem[p], wcData[p], wcMask[p]); wcMask[p] = 4'h0; modelInval(p);
    @(negedge clk);
    evictValid = 1'b0;
    chk(!rspValid, "R6", "eviction returns no data", 32'(rspValid), 0);
  endtask

  task automatic doBcast(int p);
    @(negedge clk);
    bcastValid = 1'b1; bcastAddr = poolAddr(p);
    mem[p] = $urandom; modelInval(p);
    @(negedge clk);
    bcastValid = 1'b0;
    chk(!rspValid, "R6", "broadcast returns no data", 32'(rspValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5A17));
    for (int i = 0; i < 8; i++) begin
      mem[i] = $urandom; wcMask[i] = 4'h0; wcData[i] = '0;
      mValid[i] = 1'b0; mWritten[i] = 1'b0; mOwner[i] = 0; mData[i] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(ldReady, "R1", "ready after reset", 32'(ldReady), 1);
    chk(!rspValid && !wcProbeValid && !missValid, "R1", "outputs idle after reset",
        32'({rspValid, wcProbeValid, missValid}), 0);
    doLoad(0, 4'hF, 0, 0, 0, 0);      // R1: empty cache misses
    doLoad(0, 4'h3, 0, 0, 0, 0);      // R2: now a clean hit
    // R3: store to the other tag of the same set leaves the line clean
    doStore(4, 4'hF, 32'h1122_3344);
    doLoad(0, 4'hF, 0, 0, 0, 0);
    // R3: store to resident line steers to the write cache (full hit)
    doStore(0, 4'h3, 32'hAAAA_BBBB);
    doLoad(0, 4'h3, 0, 0, 0, 0);
    // R4/R5: partial coverage flushes then misses; fill installs clean
    doLoad(0, 4'hF, 0, 0, 0, 0);
    doLoad(0, 4'hF, 0, 0, 0, 0);
    // R6: eviction invalidates, next load misses
    doStore(1, 4'hF, 32'hCAFE_0001);
    doLoad(1, 4'h1, 0, 0, 0, 0);
    doEvict(1);
    doLoad(1, 4'h1, 0, 0, 0, 0);
    doLoad(1, 4'h1, 0, 0, 0, 0);
    // R6: broadcast in the same cycle as the load is not a local hit
    doLoad(1, 4'hF, 1, 0, 0, 0);
    doLoad(1, 4'hF, 0, 0, 0, 0);
    // R3: store in the same cycle as the load steers it
    doLoad(1, 4'h1, 0, 1, 0, 0);
    // R7: invalidate in the fill cycle, data returned but not kept
    doLoad(2, 4'hF, 0, 0, 0, 1);
    doLoad(2, 4'hF, 0, 0, 0, 0);
    doLoad(2, 4'hF, 0, 0, 0, 0);
    // R8: store during the miss installs the line written
    doLoad(3, 4'hF, 0, 0, 1, 0);
    doLoad(3, 4'hC, 0, 0, 0, 0);
    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op, p;
      op = $urandom_range(0, 9);
      p  = $urandom_range(0, 7);
      if (op < 4)
        doLoad(p, 4'($urandom_range(1, 15)), ($urandom_range(0, 9) == 0),
               ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0),
               ($urandom_range(0, 7) == 0));
      else if (op < 6) doStore(p, 4'($urandom_range(1, 15)), $urandom);
      else if (op == 6) begin if (wcMask[p] != 0) doEvict(p); end
      else if (op == 7) doBcast(p);
      else @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule